// File: doc/BRIEF.md
# Sound-Generator CPU Bus Interface

This block sits between a host processor and the register bank of a sound-generator peripheral. The host drives a shared 8-bit bus that carries both register numbers and data. Three control lines (direction, control 2, control 1) tell the block what to do with the bus in each cycle. The block decodes them into four operations: idle, address capture, register read and register write. The block holds sixteen 8-bit registers. The synthesis tools can turn the separate bus input, bus output and output-enable signals into a tristate pad.

When an address is captured, the low nibble of the bus picks one of the sixteen registers. The high nibble, together with an auxiliary address pin, decides whether this chip is the one being addressed. The chip answers reads and accepts writes only after a capture that matched its own address. A capture that does not match silences the chip until the next matching capture. The control lines are sampled on the rising clock edge. The read path is combinational from the control lines and the held state, so read data is valid within the same cycle as the read code.

Top module: `psg_bus_if`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every register becomes 0x00 and the chip becomes deselected. After reset, a read returns 0x00 from every register once a matching address has been captured.
- R2: Control codes {bdir,bc2,bc1} = 001, 100 and 111 each capture an address at the clock edge. In the capture, `bus_in[3:0]` becomes the selected register index.
- R3: A capture selects the chip when `bus_in[7:4]` equals the parameter CHIP_ADDR and `aux_addr` equals the parameter AUX_LEVEL. Any other capture deselects the chip.
- R4: Code 110 with the chip selected writes `bus_in` into the indexed register at the clock edge.
- R5: Code 011 with the chip selected raises `bus_oe` and places the indexed register on `bus_out` in the same cycle, before the next edge.
- R6: Codes 000, 010 and 101 change neither the index, the chip selection nor any register, whatever is on the bus.
- R7: While the chip is deselected, code 110 leaves every register unchanged and code 011 keeps `bus_oe` low.
- R8: `bus_oe` is high only while the code is 011 and the chip is selected. In every other case the bus is left undriven.

Defaults: CHIP_ADDR = 0, AUX_LEVEL = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; control lines are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bdir | input | 1 | Bus direction control line |
| bc2 | input | 1 | Bus control line 2 |
| bc1 | input | 1 | Bus control line 1 |
| aux_addr | input | 1 | Auxiliary address bit used in the chip-select match |
| bus_in | input | 8 | Value the host places on the shared bus |
| bus_out | output | 8 | Register contents offered to the bus |
| bus_oe | output | 1 | High when the block drives the bus |

## Verification
A corrupted register index shows up at the next read as the value of a neighbouring register. A stuck or inverted chip-select flag shows up in the same cycle as an `bus_oe` that should or should not be high. A write that reaches the wrong entry, or that slips through while the chip is deselected, stays hidden until that entry is read back. For this reason the bench reads all sixteen entries after every phase that writes. An alias code that is decoded wrongly either moves the index, which the following read exposes, or drives the bus during a non-read code, which is caught in that same cycle.

// File: rtl/psg_bus_pkg.sv
// Package: shared operation type for the sound-generator bus interface.
// Assumes a 3-bit control code ordered {bdir, bc2, bc1}.
package psg_bus_pkg;
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_LATCH = 2'd1,
        OP_READ  = 2'd2,
        OP_WRITE = 2'd3
    } bus_op_e;
endpackage

// File: rtl/psg_ctl_decode.sv
// Module: maps the three bus-control lines to one operation.
// Assumes the lines are stable around the sampling edge; purely combinational.
module psg_ctl_decode
    import psg_bus_pkg::*;
(
    input  logic    bdir,
    input  logic    bc2,
    input  logic    bc1,
    output bus_op_e op
);
    logic [2:0] code;
    assign code = {bdir, bc2, bc1};

    // Purpose: decode the code; three codes alias to capture, three to idle.
    always_comb begin
        unique case (code)
            3'b001, 3'b100, 3'b111: op = OP_LATCH;
            3'b011:                 op = OP_READ;
            3'b110:                 op = OP_WRITE;
            default:                op = OP_IDLE;
        endcase
    end
endmodule

// File: rtl/psg_addr_latch.sv
// Module: holds the register index and the chip-select flag.
// Assumes the low IDX_W bus bits carry the index and the rest carry the chip tag.
module psg_addr_latch
    import psg_bus_pkg::*;
#(
    parameter int            DATA_W    = 8,
    parameter int            IDX_W     = 4,
    parameter logic [DATA_W-IDX_W-1:0] CHIP_ADDR = '0,
    parameter logic          AUX_LEVEL = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_op_e           op,
    input  logic [DATA_W-1:0] bus_in,
    input  logic              aux_addr,
    output logic [IDX_W-1:0]  idx_q,
    output logic              sel_q
);
    localparam int TAG_W = DATA_W - IDX_W;

    logic [TAG_W-1:0] tag;
    logic             hit;

    assign tag = bus_in[DATA_W-1:IDX_W];
    assign hit = (tag == CHIP_ADDR) && (aux_addr == AUX_LEVEL);

    // Purpose: capture index and select flag on an address-capture operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            sel_q <= 1'b0;
        end else if (op == OP_LATCH) begin
            idx_q <= bus_in[IDX_W-1:0];
            sel_q <= hit;
        end
    end
endmodule

// File: rtl/psg_reg_file.sv
// Module: register array with one write port and one combinational read port.
// Assumes the write enable is already qualified by chip select.
module psg_reg_file #(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);
    localparam int NREGS = 1 << IDX_W;

    logic [DATA_W-1:0] mem [NREGS];

    for (genvar g = 0; g < NREGS; g++) begin : g_entry
        // Purpose: clear on reset, load when this entry is written.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[g] <= '0;
            else if (wr_en && (idx == IDX_W'(g)))
                mem[g] <= wr_data;
        end
    end

    // Purpose: present the indexed entry.
    assign rd_data = mem[idx];
endmodule

// File: rtl/psg_bus_if.sv
// Module: top of the CPU-side bus interface of the sound generator.
// Assumes the shared bus is split into bus_in, bus_out and bus_oe for a pad.
module psg_bus_if
    import psg_bus_pkg::*;
#(
    parameter int   DATA_W    = 8,
    parameter int   IDX_W     = 4,
    parameter logic [DATA_W-IDX_W-1:0] CHIP_ADDR = '0,
    parameter logic AUX_LEVEL = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bdir,
    input  logic              bc2,
    input  logic              bc1,
    input  logic              aux_addr,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe
);
    bus_op_e           op;
    logic [IDX_W-1:0]  idx_q;
    logic              sel_q;
    logic              wr_en;

    psg_ctl_decode u_dec (
        .bdir (bdir),
        .bc2  (bc2),
        .bc1  (bc1),
        .op   (op)
    );

    psg_addr_latch #(
        .DATA_W    (DATA_W),
        .IDX_W     (IDX_W),
        .CHIP_ADDR (CHIP_ADDR),
        .AUX_LEVEL (AUX_LEVEL)
    ) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op),
        .bus_in   (bus_in),
        .aux_addr (aux_addr),
        .idx_q    (idx_q),
        .sel_q    (sel_q)
    );

    // Purpose: qualify the write with chip select.
    assign wr_en = (op == OP_WRITE) && sel_q;

    psg_reg_file #(
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .idx     (idx_q),
        .wr_data (bus_in),
        .rd_data (bus_out)
    );

    // Purpose: drive the bus only for a selected read.
    assign bus_oe = (op == OP_READ) && sel_q;
endmodule

// File: rtl/psg_bus_if_chk.sv
// Module: property checker for psg_bus_if, attached by bind.
// Assumes it sees the ports plus the held index and select flag.
module psg_bus_if_chk #(
    parameter int   DATA_W    = 8,
    parameter int   IDX_W     = 4,
    parameter logic [DATA_W-IDX_W-1:0] CHIP_ADDR = '0,
    parameter logic AUX_LEVEL = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bdir,
    input logic              bc2,
    input logic              bc1,
    input logic              aux_addr,
    input logic [DATA_W-1:0] bus_in,
    input logic              bus_oe,
    input logic [IDX_W-1:0]  idx_q,
    input logic              sel_q
);
    logic [2:0] code;
    logic       is_cap;
    logic       is_idle;
    logic       is_hit;

    assign code    = {bdir, bc2, bc1};
    assign is_cap  = (code == 3'b001) || (code == 3'b100) || (code == 3'b111);
    assign is_idle = (code == 3'b000) || (code == 3'b010) || (code == 3'b101);
    assign is_hit  = (bus_in[DATA_W-1:IDX_W] == CHIP_ADDR) && (aux_addr == AUX_LEVEL);

    // R1
    reset_deselects_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> !sel_q);

    // R2
    capture_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_cap |=> (idx_q == $past(bus_in[IDX_W-1:0])));

    // R3
    capture_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_cap |=> (sel_q == $past(is_hit)));

    // R6
    idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_idle |=> ($stable(idx_q) && $stable(sel_q)));

    // R7
    oe_needs_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> sel_q);

    // R8
    oe_only_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> (code == 3'b011));
endmodule

bind psg_bus_if psg_bus_if_chk #(
    .DATA_W    (DATA_W),
    .IDX_W     (IDX_W),
    .CHIP_ADDR (CHIP_ADDR),
    .AUX_LEVEL (AUX_LEVEL)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bdir     (bdir),
    .bc2      (bc2),
    .bc1      (bc1),
    .aux_addr (aux_addr),
    .bus_in   (bus_in),
    .bus_oe   (bus_oe),
    .idx_q    (u_addr.idx_q),
    .sel_q    (u_addr.sel_q)
);

// File: tb/psg_bus_if_bench.sv
module psg_bus_if_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bdir = 1'b0, bc2 = 1'b0, bc1 = 1'b0, aux_addr = 1'b0;
    logic [7:0] bus_in = '0;
    logic [7:0] bus_out;
    logic       bus_oe;

    int tests = 0;
    int fails = 0;
    logic [7:0] exp_mem [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    psg_bus_if u_psg_bus_if (
        .clk(clk), .rst_n(rst_n), .bdir(bdir), .bc2(bc2), .bc1(bc1),
        .aux_addr(aux_addr), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe)
    );

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one operation over one clock cycle, driven after the falling edge
    task automatic op(input logic [2:0] code, input logic [7:0] d, input logic aux);
        @(negedge clk);
        {bdir, bc2, bc1} = code;
        bus_in = d;
        aux_addr = aux;
        @(posedge clk);
        #1;
    endtask

    // read code mid-cycle; compare enable and data
    task automatic rd(input string req, input logic oe_exp, input logic [7:0] d_exp);
        @(negedge clk);
        {bdir, bc2, bc1} = 3'b011;
        bus_in = 8'h5A;
        aux_addr = 1'b0;
        #1;
        if (oe_exp) check(req, {bus_oe, bus_out}, {1'b1, d_exp});
        else        check(req, {8'h00, bus_oe}, 9'h000);
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [2:0] caps [3];
        caps[0] = 3'b001; caps[1] = 3'b100; caps[2] = 3'b111;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;

        // R1: deselected after reset -> no drive; then all entries read zero
        rd("R1 deselected after reset", 1'b0, 8'h00);
        for (int i = 0; i < 16; i++) begin
            op(caps[i % 3], 8'(i), 1'b0);
            rd("R1 reset value", 1'b1, 8'h00);
        end

        // R2 R4 R5: write every entry via every capture alias, read all back
        for (int i = 0; i < 16; i++) begin
            exp_mem[i] = 8'((i * 37 + 5) & 8'hFF);
            op(caps[(i + 1) % 3], 8'(i), 1'b0);
            op(3'b110, exp_mem[i], 1'b0);
        end
        for (int i = 0; i < 16; i++) begin
            op(caps[(i + 2) % 3], 8'(i), 1'b0);
            rd("R2 R4 R5 readback", 1'b1, exp_mem[i]);
        end

        // R6: idle codes with bus noise leave index, select and data alone
        op(3'b001, 8'h03, 1'b0);
        op(3'b000, 8'h5C, 1'b1);
        op(3'b010, 8'hFA, 1'b0);
        op(3'b101, 8'h0E, 1'b0);
        rd("R6 idle codes", 1'b1, exp_mem[3]);

        // R8: every code, selected, enable only on 011
        for (int c = 0; c < 8; c++) begin
            op(3'b001, 8'h07, 1'b0);
            @(negedge clk);
            {bdir, bc2, bc1} = 3'(c);
            bus_in = 8'h07;
            #1;
            check("R8 oe per code", {8'h00, bus_oe}, {8'h00, (c == 3)});
            @(posedge clk);
            #1;
        end
        // the 110 pass rewrote entry 7 with 0x07
        exp_mem[7] = 8'h07;
        op(3'b100, 8'h07, 1'b0);
        rd("R8 write under sweep", 1'b1, 8'h07);

        // R3 R7: tag mismatch deselects; write ignored, read silent
        op(3'b111, 8'h52, 1'b0);
        rd("R3 tag mismatch silences", 1'b0, 8'h00);
        op(3'b110, 8'hFF, 1'b0);
        op(3'b001, 8'h12, 1'b0);
        rd("R3 R7 wrong-tag capture", 1'b0, 8'h00);
        op(3'b001, 8'h02, 1'b1);
        rd("R3 aux mismatch silences", 1'b0, 8'h00);
        op(3'b110, 8'hEE, 1'b1);
        op(3'b001, 8'h02, 1'b0);
        rd("R3 R7 reselect, entry 2 kept", 1'b1, exp_mem[2]);
        for (int i = 0; i < 16; i++) begin
            op(caps[i % 3], 8'(i), 1'b0);
            rd("R7 no stray writes", 1'b1, exp_mem[i]);
        end

        // R1: reset mid-run clears data and select
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        rd("R1 select cleared", 1'b0, 8'h00);
        op(3'b001, 8'h0B, 1'b0);
        rd("R1 data cleared", 1'b1, 8'h00);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule